// File: doc/BRIEF.md
# Counter-Sequenced Interrupt Memory Overlay

This block lets a CPU run a short, branch-free interrupt handler out of a small private memory without the CPU ever taking an interrupt. When a request arrives, a mapping flip-flop switches fetches away from main memory and onto an overlay memory. The overlay is addressed by a counter that restarts at zero on every accepted request. The CPU keeps driving whatever address its program counter holds, but while the overlay is mapped the low address bits are replaced by the counter. Because the overlay is only partially decoded, it answers across the whole address space.

Each completed fetch strobe advances the counter, so the handler executes as a straight line of sequential fetches. A return indication from the handler switches main memory back in at the end of the current fetch. The CPU then carries on from where it was, with no stack push or pop. A run-length output reports how many fetches the most recent handler run took.

Top module: `ovl_fetch_mapper`

## Requirements
- R1: After reset, main memory is enabled, the overlay is disabled, the overlay address is 0 and the run length is 0.
- R2: A request while the overlay is unmapped maps the overlay on the next cycle: ovl_en is 1, main_en is 0 and the overlay address restarts at 0.
- R3: main_en and ovl_en are always complements of each other.
- R4: While the overlay is mapped, the low OW bits of mem_addr carry the overlay counter and the upper bits pass cpu_addr through unchanged. The overlay address does not depend on cpu_addr.
- R5: While the overlay is mapped, each cycle with fetch_stb high advances the overlay address by one. Cycles without a strobe, and strobes while unmapped, leave it unchanged.
- R6: The overlay address wraps from 2^OW-1 to 0.
- R7: A return indication sampled together with a fetch strobe unmaps the overlay on the next cycle, and that final strobe is still counted.
- R8: A return indication without a strobe is held pending. The overlay stays mapped until the next strobe and unmaps on the cycle after it.
- R9: A request that arrives while the overlay is mapped is ignored, and the counter is not restarted.
- R10: When a run ends, run_len takes the number of strobes in that run. It holds that value through the next run until that run ends.
- R11: While the overlay is unmapped, mem_addr equals cpu_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 1 | Handler request |
| fetch_stb | input | 1 | Completed fetch, one cycle per fetch |
| ret_req | input | 1 | Handler return indication |
| cpu_addr | input | AW | Address driven by the CPU |
| main_en | output | 1 | Main memory enable |
| ovl_en | output | 1 | Overlay memory enable |
| ovl_addr | output | OW | Overlay address (sequencing counter) |
| mem_addr | output | AW | Address presented to the memory system |
| run_len | output | LW | Strobe count of the last finished run |

## Verification
The bench builds the block with AW=16, OW=4 and LW=8. A 4-bit overlay makes the counter wrap after only sixteen fetches, so one 20-fetch handler run crosses the wrap point and the run length still reads 20. The 16-bit address keeps a non-trivial upper part that must pass through. A mid-run request and a return raised without a strobe are placed inside that long run, so a wrongly restarted counter or an early unmap shows up in the sequence of fetched addresses.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef struct packed {
        logic mapped;
        logic ret_pend;
    } map_state_t;

    localparam map_state_t MAP_RESET = '{mapped: 1'b0, ret_pend: 1'b0};

endpackage

// File: rtl/ovl_map_ctrl.sv
module ovl_map_ctrl
    import ovl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic fetch_stb_i,
    input  logic ret_i,
    output logic mapped_o,
    output logic start_o,
    output logic advance_o,
    output logic finish_o
);

    map_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        start_o   = !st_q.mapped && req_i;
        advance_o = st_q.mapped && fetch_stb_i;
        finish_o  = advance_o && (ret_i || st_q.ret_pend);

        if (start_o) begin
            st_d.mapped   = 1'b1;
            st_d.ret_pend = 1'b0;
        end
        // return seen between strobes: remember it until the next strobe
        if (st_q.mapped && ret_i && !fetch_stb_i) begin
            st_d.ret_pend = 1'b1;
        end
        if (finish_o) begin
            st_d.mapped   = 1'b0;
            st_d.ret_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MAP_RESET;
        else        st_q <= st_d;
    end

    assign mapped_o = st_q.mapped;

endmodule

// File: rtl/ovl_seq_counter.sv
module ovl_seq_counter #(
    parameter int OW = 8,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          advance_i,
    input  logic          finish_i,
    output logic [OW-1:0] addr_o,
    output logic [LW-1:0] run_len_o
);

    typedef struct packed {
        logic [OW-1:0] cnt;
        logic [LW-1:0] len;
        logic [LW-1:0] last;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.cnt = '0;
            s_d.len = '0;
        end
        if (advance_i) begin
            s_d.cnt = s_q.cnt + 1'b1;
            s_d.len = s_q.len + 1'b1;
        end
        if (finish_i) begin
            s_d.last = s_q.len + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr_o    = s_q.cnt;
    assign run_len_o = s_q.last;

endmodule

// File: rtl/ovl_addr_mux.sv
module ovl_addr_mux #(
    parameter int AW = 16,
    parameter int OW = 8
) (
    input  logic          mapped_i,
    input  logic [AW-1:0] cpu_addr_i,
    input  logic [OW-1:0] ovl_addr_i,
    output logic [AW-1:0] mem_addr_o
);

    for (genvar b = 0; b < AW; b++) begin : g_bit
        if (b < OW) begin : g_low
            assign mem_addr_o[b] = mapped_i ? ovl_addr_i[b] : cpu_addr_i[b];
        end else begin : g_high
            assign mem_addr_o[b] = cpu_addr_i[b];
        end
    end

endmodule

// File: rtl/ovl_fetch_mapper.sv
module ovl_fetch_mapper #(
    parameter int AW = 16,
    parameter int OW = 8,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_req,
    input  logic          fetch_stb,
    input  logic          ret_req,
    input  logic [AW-1:0] cpu_addr,
    output logic          main_en,
    output logic          ovl_en,
    output logic [OW-1:0] ovl_addr,
    output logic [AW-1:0] mem_addr,
    output logic [LW-1:0] run_len
);

    logic mapped, start, advance, finish;

    ovl_map_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (irq_req),
        .fetch_stb_i(fetch_stb),
        .ret_i      (ret_req),
        .mapped_o   (mapped),
        .start_o    (start),
        .advance_o  (advance),
        .finish_o   (finish)
    );

    ovl_seq_counter #(.OW(OW), .LW(LW)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .advance_i (advance),
        .finish_i  (finish),
        .addr_o    (ovl_addr),
        .run_len_o (run_len)
    );

    ovl_addr_mux #(.AW(AW), .OW(OW)) i_mux (
        .mapped_i   (mapped),
        .cpu_addr_i (cpu_addr),
        .ovl_addr_i (ovl_addr),
        .mem_addr_o (mem_addr)
    );

    assign ovl_en  = mapped;
    assign main_en = !mapped;

endmodule

// File: rtl/ovl_fetch_mapper_chk.sv
module ovl_fetch_mapper_chk #(
    parameter int AW = 16,
    parameter int OW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_req,
    input logic          fetch_stb,
    input logic          ret_req,
    input logic [AW-1:0] cpu_addr,
    input logic          main_en,
    input logic          ovl_en,
    input logic [OW-1:0] ovl_addr,
    input logic [AW-1:0] mem_addr
);

    p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        main_en != ovl_en);

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovl_en && irq_req) |=> (ovl_en && ovl_addr == '0));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_en && fetch_stb) |=> (ovl_addr == OW'($past(ovl_addr) + 1'b1)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_en && !fetch_stb) |=> (ovl_en && $stable(ovl_addr)));

    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovl_en && !irq_req) |=> (!ovl_en && $stable(ovl_addr)));

    p_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_en && fetch_stb && ret_req) |=> !ovl_en);

    p_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_en |-> (mem_addr == cpu_addr));

    p_over_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_en |-> (mem_addr[OW-1:0] == ovl_addr && mem_addr[AW-1:OW] == cpu_addr[AW-1:OW]));

endmodule

bind ovl_fetch_mapper ovl_fetch_mapper_chk #(.AW(AW), .OW(OW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .fetch_stb(fetch_stb),
    .ret_req  (ret_req),
    .cpu_addr (cpu_addr),
    .main_en  (main_en),
    .ovl_en   (ovl_en),
    .ovl_addr (ovl_addr),
    .mem_addr (mem_addr)
);

// File: tb/test_ovl_fetch_mapper.sv
module test_ovl_fetch_mapper;

    localparam int AW = 16;
    localparam int OW = 4;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_req = 1'b0;
    logic          fetch_stb = 1'b0;
    logic          ret_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          main_en, ovl_en;
    logic [OW-1:0] ovl_addr;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] run_len;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [OW-1:0] sb[$];

    always #2 clk = ~clk;

    ovl_fetch_mapper #(.AW(AW), .OW(OW), .LW(LW)) i_ovl_fetch_mapper (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fetch_stb(fetch_stb),
        .ret_req(ret_req), .cpu_addr(cpu_addr), .main_en(main_en),
        .ovl_en(ovl_en), .ovl_addr(ovl_addr), .mem_addr(mem_addr), .run_len(run_len)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: every mapped fetch must present the next address in the queue
    always @(negedge clk) begin
        if (rst_n && ovl_en && fetch_stb) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R5 actual=%0h expected=none (unexpected fetch)", ovl_addr);
            end else begin
                logic [OW-1:0] e;
                e = sb.pop_front();
                check("R5/R6/R9 fetch address", 32'(ovl_addr), 32'(e));
                check("R4 mapped bus address", 32'(mem_addr), 32'({cpu_addr[AW-1:OW], e}));
            end
        end
    end

    task automatic fetch(input logic [OW-1:0] exp, input bit r, input bit q);
        sb.push_back(exp);
        @(posedge clk); #1;
        fetch_stb = 1'b1; ret_req = r; irq_req = q;
        @(posedge clk); #1;
        fetch_stb = 1'b0; ret_req = 1'b0; irq_req = 1'b0;
    endtask

    task automatic request();
        @(posedge clk); #1; irq_req = 1'b1;
        @(posedge clk); #1; irq_req = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cpu_addr = 16'h1234;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 main_en", 32'(main_en), 1);
        check("R1 ovl_en", 32'(ovl_en), 0);
        check("R1 ovl_addr", 32'(ovl_addr), 0);
        check("R1 run_len", 32'(run_len), 0);
        check("R11 unmapped address", 32'(mem_addr), 32'h1234);

        // strobe while unmapped: no effect
        @(posedge clk); #1 fetch_stb = 1'b1;
        @(posedge clk); #1 fetch_stb = 1'b0;
        @(negedge clk);
        check("R5 unmapped strobe ignored", 32'(ovl_addr), 0);
        check("R3 main enabled", 32'(main_en), 1);

        // run A: five fetches, return with the last strobe
        request();
        @(negedge clk);
        check("R2 ovl_en", 32'(ovl_en), 1);
        check("R2 main_en", 32'(main_en), 0);
        check("R2 ovl_addr", 32'(ovl_addr), 0);
        cpu_addr = 16'hABCD;
        #0;
        @(negedge clk);
        check("R4 high bits pass", 32'(mem_addr), 32'hABC0);
        for (int k = 0; k < 5; k++) fetch(OW'(k), k == 4, 1'b0);
        @(negedge clk);
        check("R7 unmapped after return", 32'(ovl_en), 0);
        check("R7 last strobe counted", 32'(ovl_addr), 5);
        check("R10 run length A", 32'(run_len), 5);
        check("R11 unmapped address", 32'(mem_addr), 32'hABCD);

        // run B: 20 fetches across the wrap, mid-run request, pending return
        cpu_addr = 16'h5E70;
        request();
        for (int k = 0; k < 19; k++) begin
            fetch(OW'(k), 1'b0, k == 7);
            if (k == 10) begin
                @(posedge clk); #1 irq_req = 1'b1;
                @(posedge clk); #1 irq_req = 1'b0;
            end
        end
        @(negedge clk);
        check("R10 run length held during run", 32'(run_len), 5);
        @(posedge clk); #1 ret_req = 1'b1;
        @(posedge clk); #1 ret_req = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8 still mapped while return pending", 32'(ovl_en), 1);
        check("R8 no advance while pending", 32'(ovl_addr), 3);
        fetch(OW'(19), 1'b0, 1'b0);
        @(negedge clk);
        check("R8 unmapped after next strobe", 32'(ovl_en), 0);
        check("R6 wrapped address", 32'(ovl_addr), 4);
        check("R10 run length B", 32'(run_len), 20);

        // run C: three fetches
        request();
        for (int k = 0; k < 3; k++) fetch(OW'(k), k == 2, 1'b0);
        @(negedge clk);
        check("R10 run length C", 32'(run_len), 3);
        check("R3 main re-enabled", 32'(main_en), 1);
        check("R5 scoreboard drained", 32'(sb.size()), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule